// File: doc/BRIEF.md
# Guarded Host Window into an Engine-Owned RAM

This block gives a host processor indirect access to a small data RAM that an embedded engine uses for its own work. The host writes a 16-bit command word carrying an operation code and a word address. It then polls a completion flag in the same register and collects the result from a 16-bit data register. For a write, the host loads the data register before it writes the command.

The engine always has the RAM when it asks for it. A host access only takes a cycle that the engine leaves idle. If the engine never leaves a cycle idle, a starvation counter forces the host access through after a fixed number of waiting cycles, so every host access finishes within `STARVE_LIM` cycles.

A configuration-state input guards host writes. In the default-configuration state every word can be written. In any other state only one reserved word can be written. A refused write leaves the RAM untouched and returns zero. A write that is allowed returns the value read back from the RAM on the following cycle.

Top module: `ramwin_port`

## Requirements
- R1: The command word carries the operation code in bits 15:12 and the word address in bits 11:1, of which the low `AW` bits select the RAM word. Code 0x0 is a read and code 0x3 is a write. Reading the command register returns the stored opcode and address field, with the completion flag in bit 0.
- R2: Writing a read or write command while the block is idle clears the completion flag on the next cycle. The flag is set again when the access finishes.
- R3: When a read finishes, the data register holds the RAM word at the commanded address.
- R4: An allowed write stores the data register into the RAM word. The block reads that word back on the next cycle and places it in the data register.
- R5: A refused write leaves the RAM unchanged, loads 0x0000 into the data register and still sets the completion flag.
- R6: With `cfg_default` high, a write to any address is allowed. With `cfg_default` low, only a write to `RSV_ADDR` (0x70 by default) is allowed.
- R7: While a host access waits and the forcing limit has not been reached, an engine request is always served (`eng_stall` low).
- R8: A host read or write finishes within `STARVE_LIM` cycles (1000 by default) after it is accepted, even if the engine requests every cycle.
- R9: Reads are allowed in every configuration state.
- R10: While an access is pending (flag low), writes to the command register or the data register are ignored.
- R11: A command with any other opcode is stored but finishes at once: the flag stays set and the data register does not change.
- R12: After reset the command register reads 0x0001 (flag set) and the data register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the engine and the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_default | input | 1 | High while the engine is in its default-configuration state |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 16 | Command word: opcode and address |
| dat_wr | input | 1 | Host write strobe for the data register |
| dat_wdata | input | 16 | Data to be written by a later write command |
| cmd_rdata | output | 16 | Command register readback with the completion flag in bit 0 |
| dat_rdata | output | 16 | Data register: read result, write read-back, or zero |
| eng_req | input | 1 | Engine requests the RAM this cycle |
| eng_we | input | 1 | Engine request is a write |
| eng_addr | input | AW | Engine word address |
| eng_wdata | input | 16 | Engine write data |
| eng_rdata | output | 16 | RAM word at `eng_addr` |
| eng_stall | output | 1 | Engine request refused this cycle because the host holds the RAM |

## Verification
The bench fills the RAM through the engine side. It then checks that, outside the default state, a write to an ordinary address comes back as zero and that a later read still returns the old word. A guard that leaked would corrupt engine data. The bench also holds the engine request high without a break. It checks that the engine is not stalled early, and that a read and a write both still finish inside the limit. A design without forcing would hang, and one that forced too early would stall the engine. A command written while an access is pending must not change the register readback, and an unknown opcode must leave the flag and the data untouched. A design that got these wrong would show a changed readback, or a flag that drops.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;
  localparam int CMD_W = 16;
  localparam logic [3:0] OP_RD = 4'h0;
  localparam logic [3:0] OP_WR = 4'h3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RDBK = 2'd2
  } win_st_e;
endpackage

// File: rtl/ramwin_ram.sv
module ramwin_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ramwin_arb.sv
module ramwin_arb #(
  parameter int STARVE_LIM = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic eng_req,
  output logic grant
);
  localparam int FORCE_AT = STARVE_LIM - 3;
  localparam int CW       = $clog2(STARVE_LIM);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          forced;

  assign forced = (cnt_q == CW'(FORCE_AT));
  assign grant  = pend && (!eng_req || forced);

  always_comb begin
    cnt_d = cnt_q;
    if (!pend || grant) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ramwin_guard.sv
module ramwin_guard #(
  parameter int          AW       = 8,
  parameter logic [10:0] RSV_ADDR = 11'h070
) (
  input  logic          cfg_default,
  input  logic [AW-1:0] addr,
  output logic          allow
);
  assign allow = cfg_default || (addr == RSV_ADDR[AW-1:0]);
endmodule

// File: rtl/ramwin_port.sv
module ramwin_port #(
  parameter int          AW         = 8,
  parameter int          STARVE_LIM = 1000,
  parameter logic [10:0] RSV_ADDR   = 11'h070
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_default,
  input  logic          cmd_wr,
  input  logic [15:0]   cmd_wdata,
  input  logic          dat_wr,
  input  logic [15:0]   dat_wdata,
  output logic [15:0]   cmd_rdata,
  output logic [15:0]   dat_rdata,
  input  logic          eng_req,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [15:0]   eng_wdata,
  output logic [15:0]   eng_rdata,
  output logic          eng_stall
);
  import ramwin_pkg::*;

  win_st_e     st_q, st_d;
  logic [3:0]  op_q, op_d;
  logic [10:0] adr_q, adr_d;
  logic        done_q, done_d;
  logic [15:0] dat_q, dat_d;

  logic          grant, allow, host_sel, host_we;
  logic [AW-1:0] host_addr, ram_addr;
  logic [15:0]   ram_q, ram_wdata;
  logic          ram_we;
  logic          unused_cmd_bit0;

  assign unused_cmd_bit0 = cmd_wdata[0];
  assign host_addr       = adr_q[AW-1:0];

  ramwin_arb #(.STARVE_LIM(STARVE_LIM)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(st_q == ST_WAIT),
    .eng_req(eng_req), .grant(grant)
  );

  ramwin_guard #(.AW(AW), .RSV_ADDR(RSV_ADDR)) u_guard (
    .cfg_default(cfg_default), .addr(host_addr), .allow(allow)
  );

  assign host_sel  = (st_q == ST_RDBK) || (st_q == ST_WAIT && grant);
  assign ram_addr  = host_sel ? host_addr : eng_addr;
  assign ram_we    = host_we || (eng_req && eng_we && !host_sel);
  assign ram_wdata = host_we ? dat_q : eng_wdata;
  assign eng_stall = eng_req && host_sel;
  assign eng_rdata = ram_q;

  ramwin_ram #(.DW(16), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    adr_d   = adr_q;
    done_d  = done_q;
    dat_d   = dat_q;
    host_we = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (dat_wr) dat_d = dat_wdata;
        if (cmd_wr) begin
          op_d  = cmd_wdata[15:12];
          adr_d = cmd_wdata[11:1];
          if (cmd_wdata[15:12] == OP_RD || cmd_wdata[15:12] == OP_WR) begin
            done_d = 1'b0;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (grant) begin
          if (op_q == OP_RD) begin
            dat_d  = ram_q;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (allow) begin
            host_we = 1'b1;
            st_d    = ST_RDBK;
          end else begin
            dat_d  = '0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_RDBK: begin
        dat_d  = ram_q;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      adr_q  <= '0;
      done_q <= 1'b1;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      adr_q  <= adr_d;
      done_q <= done_d;
      dat_q  <= dat_d;
    end
  end

  assign cmd_rdata = {op_q, adr_q, done_q};
  assign dat_rdata = dat_q;
endmodule

// File: rtl/ramwin_chk.sv
module ramwin_chk #(
  parameter int          AW         = 8,
  parameter int          STARVE_LIM = 1000,
  parameter logic [10:0] RSV_ADDR   = 11'h070
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_default,
  input logic          cmd_wr,
  input logic [3:0]    cmd_op,
  input logic [15:0]   cmd_rdata,
  input logic [15:0]   dat_rdata,
  input logic          eng_req,
  input logic          eng_stall,
  input logic          host_we,
  input logic [AW-1:0] host_addr
);
  localparam int WW = $clog2(STARVE_LIM) + 2;

  logic [WW-1:0] wcnt;
  logic          known_op;

  assign known_op = (cmd_op == 4'h0) || (cmd_op == 4'h3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wcnt <= '0;
    else if (cmd_rdata[0])           wcnt <= '0;
    else if (wcnt != {WW{1'b1}})     wcnt <= wcnt + 1'b1;
  end

  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_rdata[0] && known_op) |=> !cmd_rdata[0]);

  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rdata[0]) |=> $stable(cmd_rdata[15:1]));

  a_r11_bad_op_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_rdata[0] && !known_op) |=> (cmd_rdata[0] && $stable(dat_rdata)));

  a_r6_guard_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> (cfg_default || host_addr == RSV_ADDR[AW-1:0]));

  a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[0] |-> (wcnt < WW'(STARVE_LIM)));

  a_r7_engine_first: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && $past(eng_req) && !cmd_rdata[0] && wcnt < WW'(STARVE_LIM - 3))
      |-> !eng_stall);
endmodule

bind ramwin_port ramwin_chk #(.AW(AW), .STARVE_LIM(STARVE_LIM), .RSV_ADDR(RSV_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_default(cfg_default), .cmd_wr(cmd_wr),
  .cmd_op(cmd_wdata[15:12]), .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata),
  .eng_req(eng_req), .eng_stall(eng_stall), .host_we(host_we), .host_addr(host_addr)
);

// File: tb/sim_ramwin_port.sv
`timescale 1ns/1ps
module sim_ramwin_port;
  localparam int AW  = 8;
  localparam int LIM = 1000;

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } sb_item_t;

  logic          clk, rst_n, cfg_default, cmd_wr, dat_wr;
  logic [15:0]   cmd_wdata, dat_wdata, cmd_rdata, dat_rdata, eng_wdata, eng_rdata;
  logic          eng_req, eng_we, eng_stall;
  logic [AW-1:0] eng_addr;

  sb_item_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;

  ramwin_port #(.AW(AW), .STARVE_LIM(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_default(cfg_default),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_stall(eng_stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd_word(input logic [3:0] op, input logic [10:0] a);
    return {op, a, 1'b0};
  endfunction

  // Scoreboard monitor: compares the data register when an access completes.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0 && cmd_rdata[0]) begin
        sb_item_t it;
        it = sbq.pop_front();
        check(dat_rdata == it.exp, it.tag, dat_rdata, it.exp);
      end
    end
  end

  task automatic wait_sb();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic host_read(input logic [10:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = cmd_word(4'h0, a);
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata == cmd_word(4'h0, a), "R1 R2 readback with flag low", cmd_rdata, cmd_word(4'h0, a));
    sbq.push_back('{tag, exp});
    wait_sb();
  endtask

  task automatic host_write(input logic [10:0] a, input logic [15:0] d, input logic [15:0] exp, input string tag);
    @(negedge clk);
    dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wr = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = cmd_word(4'h3, a);
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata[0] == 1'b0, "R2 flag cleared on write cmd", {15'd0, cmd_rdata[0]}, 16'h0000);
    sbq.push_back('{tag, exp});
    wait_sb();
  endtask

  task automatic eng_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = a; eng_wdata = d;
    @(negedge clk);
    eng_req = 1'b0; eng_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual 0x%04h expected 0x%04h", cmd_rdata, 16'h0001);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; cfg_default = 1'b0; cmd_wr = 1'b0; dat_wr = 1'b0;
    cmd_wdata = '0; dat_wdata = '0; eng_req = 1'b0; eng_we = 1'b0;
    eng_addr = '0; eng_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_rdata == 16'h0001, "R12 reset command reg", cmd_rdata, 16'h0001);
    check(dat_rdata == 16'h0000, "R12 reset data reg", dat_rdata, 16'h0000);

    eng_write(8'h10, 16'h1234);
    eng_write(8'h20, 16'h5A5A);
    eng_write(8'h70, 16'hBEEF);
    eng_addr = 8'h20;
    @(negedge clk);
    check(eng_rdata == 16'h5A5A, "R3 engine-side preload", eng_rdata, 16'h5A5A);

    // Non-default state: read allowed, write to ordinary address refused.
    host_read(11'h010, 16'h1234, "R3 R9 read in non-default state");
    host_write(11'h020, 16'hFFFF, 16'h0000, "R5 R6 refused write returns zero");
    host_read(11'h020, 16'h5A5A, "R5 refused write left RAM intact");
    host_write(11'h070, 16'h4321, 16'h4321, "R4 R6 reserved address write read-back");
    host_read(11'h070, 16'h4321, "R4 reserved word holds new value");

    // Default state: any address writable.
    cfg_default = 1'b1;
    host_write(11'h020, 16'h0F0F, 16'h0F0F, "R4 R6 write in default state");
    host_read(11'h020, 16'h0F0F, "R6 default-state write stored");

    // Unknown opcode: completes at once, data untouched.
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = cmd_word(4'h5, 11'h010);
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata == (cmd_word(4'h5, 11'h010) | 16'h0001), "R11 R1 unknown opcode stored, flag set",
          cmd_rdata, cmd_word(4'h5, 11'h010) | 16'h0001);
    check(dat_rdata == 16'h0F0F, "R11 data unchanged", dat_rdata, 16'h0F0F);

    // Engine saturates the RAM; host read must still finish.
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b0; eng_addr = 8'h10;
    cmd_wr = 1'b1; cmd_wdata = cmd_word(4'h0, 11'h010);
    @(negedge clk);
    cmd_wdata = cmd_word(4'h3, 11'h070);
    dat_wr = 1'b1; dat_wdata = 16'h9999;
    @(negedge clk);
    cmd_wr = 1'b0; dat_wr = 1'b0;
    lat = 2;
    check(cmd_rdata == cmd_word(4'h0, 11'h010), "R10 command ignored while pending",
          cmd_rdata, cmd_word(4'h0, 11'h010));
    check(eng_stall == 1'b0, "R7 engine served while host waits", {15'd0, eng_stall}, 16'h0000);
    repeat (100) @(negedge clk);
    lat += 100;
    check(eng_stall == 1'b0 && cmd_rdata[0] == 1'b0, "R7 host still yielding", {15'd0, cmd_rdata[0]}, 16'h0000);
    while (!cmd_rdata[0] && lat < 2 * LIM) begin @(negedge clk); lat++; end
    check(lat <= LIM, "R8 forced read latency", 16'(lat), 16'(LIM));
    check(dat_rdata == 16'h1234, "R8 R3 forced read data", dat_rdata, 16'h1234);

    // Forced write under saturation, default state.
    @(negedge clk);
    dat_wr = 1'b1; dat_wdata = 16'h7777;
    @(negedge clk);
    dat_wr = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = cmd_word(4'h3, 11'h030);
    @(negedge clk);
    cmd_wr = 1'b0;
    lat = 1;
    while (!cmd_rdata[0] && lat < 2 * LIM) begin @(negedge clk); lat++; end
    check(lat <= LIM, "R8 forced write latency", 16'(lat), 16'(LIM));
    check(dat_rdata == 16'h7777, "R8 R4 forced write read-back", dat_rdata, 16'h7777);
    @(negedge clk);
    eng_req = 1'b0;
    host_read(11'h030, 16'h7777, "R4 forced write stored");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule